// File: doc/BRIEF.md
# Snooping MESI Coherence Controller

This block keeps the coherence state of every line in a small private, direct-mapped cache that sits on a shared broadcast bus. The low bits of a block address select a line and the remaining bits form its tag. Each line is Invalid, Shared, Exclusive or Modified. Data storage, memory, bus arbitration and the choice of victim lie outside the block. An eviction appears only as a write-back request carrying the old block address.

The processor side presents one read or write at a time. It holds `cpu_req` until `cpu_done` pulses, and `cpu_hit` then tells whether the access needed the bus. On a miss or an upgrade the controller raises `bus_req` with a command and address, and keeps the processor stalled until `bus_gnt` arrives. The transaction is taken to complete in the granted cycle, and the wired shared line is sampled in that same cycle. The snoop side watches other caches' transactions. One cycle after a snoop it drives the shared response, and it flags when this cache must supply dirty data.

Top module: `mesi_coherence_ctrl`

## Requirements
- R1: After reset every line is Invalid and all outputs are low, so the first access to any address misses.
- R2: A read to a line that is Invalid or holds another tag issues command 01 (read). The line fills as Exclusive when `bus_shared_in` is low in the grant cycle and as Shared when it is high.
- R3: A read to a valid line with a matching tag completes one cycle after acceptance with `cpu_done` and `cpu_hit` high. It issues no bus request and leaves the state unchanged.
- R4: A write to a line that is Invalid or holds another tag issues command 10 (read-exclusive), and the line becomes Modified.
- R5: A write to a Shared line issues command 11 (upgrade), and the line becomes Modified.
- R6: A write to an Exclusive line completes as a hit with no bus request, and the line becomes Modified.
- R7: A snooped read (01) that matches a Modified line raises `snp_flush` and `snp_shared` one cycle later and moves the line to Shared.
- R8: A snooped read that matches an Exclusive or Shared line raises `snp_shared` without `snp_flush` one cycle later. An Exclusive line moves to Shared.
- R9: A snooped read-exclusive (10) or upgrade (11) that matches a valid line moves it to Invalid. A read-exclusive that hits a Modified line also raises `snp_flush`.
- R10: A snoop whose address matches no valid line (wrong tag or Invalid line) raises no response and changes no state.
- R11: While a bus request is pending, `bus_req`, `bus_addr` and `cpu_stall` stay high or stable and `cpu_done` stays low until `bus_gnt`. The request then completes in one cycle. If a snoop invalidates a pending upgrade's line, the command becomes read-exclusive.
- R12: A miss that replaces a Modified line with another tag pulses `wb_req` in the completion cycle, with `wb_addr` set to the evicted block address. Replacing a clean line pulses nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Processor block address |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_hit | output | 1 | With `cpu_done`: access completed without the bus |
| cpu_stall | output | 1 | A bus transaction is pending |
| bus_req | output | 1 | Bus transaction request |
| bus_cmd | output | 2 | 00 none, 01 read, 10 read-exclusive, 11 upgrade |
| bus_addr | output | AW | Address of the pending transaction |
| bus_gnt | input | 1 | Grant; the transaction completes in this cycle |
| bus_shared_in | input | 1 | Wired shared line, sampled on grant |
| snp_valid | input | 1 | A foreign transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same encoding as `bus_cmd` |
| snp_addr | input | AW | Snooped block address |
| snp_shared | output | 1 | Shared response, one cycle after the snoop |
| snp_flush | output | 1 | Must supply dirty data, one cycle after the snoop |
| wb_req | output | 1 | Write-back pulse for an evicted Modified line |
| wb_addr | output | AW | Evicted block address |

## Verification
The bench attacks the states that look alike at the ports. It tells Exclusive from Shared by whether a later write is silent or asks for an upgrade, and it tells Modified from Exclusive by whether a snooped read flushes. A controller that filled with the wrong sense of the shared line, or that forgot to downgrade on a snooped read, would issue the wrong command on a later write. Snoops that match the index but not the tag are sent to show that a design comparing only the index would wrongly invalidate or flush. One upgrade is invalidated by a snoop while it waits for a grant. A design that latched its command at request time would then still send an upgrade for a line it no longer holds. Evictions of dirty and clean lines check that only the dirty one asks for a write-back, with the old address and not the new one.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } line_st_t;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_RD   = 2'd1,
    CMD_RDX  = 2'd2,
    CMD_UPGR = 2'd3
  } bus_cmd_t;

  typedef struct packed {
    line_st_t nxt;
    logic     shared;
    logic     flush;
  } snp_resp_t;

  // Reaction of a held line to a foreign transaction (R7, R8, R9)
  function automatic snp_resp_t snoop_react(line_st_t cur, bus_cmd_t cmd);
    snp_resp_t r;
    r.nxt    = cur;
    r.shared = 1'b0;
    r.flush  = 1'b0;
    if (cur != ST_I) begin
      case (cmd)
        CMD_RD: begin
          r.nxt    = ST_S;
          r.shared = 1'b1;
          r.flush  = (cur == ST_M);
        end
        CMD_RDX: begin
          r.nxt   = ST_I;
          r.flush = (cur == ST_M);
        end
        CMD_UPGR: r.nxt = ST_I;
        default: ;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
  import mesi_pkg::*;
#(
  parameter int NLINES = 8,
  parameter int TW     = 13,
  localparam int IW    = $clog2(NLINES)
) (
  input  logic          clk,
  input  logic          rst,
  // read port for the processor side
  input  logic [IW-1:0] p_idx,
  output line_st_t      p_st,
  output logic [TW-1:0] p_tag,
  // read port for the snoop side
  input  logic [IW-1:0] s_idx,
  output line_st_t      s_st,
  output logic [TW-1:0] s_tag,
  // processor-side write: state and tag, wins on a collision
  input  logic          p_we,
  input  line_st_t      p_wst,
  input  logic [TW-1:0] p_wtag,
  // snoop-side write: state only
  input  logic          s_we,
  input  line_st_t      s_wst
);

  line_st_t      st_q  [NLINES];
  logic [TW-1:0] tag_q [NLINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NLINES; i++) begin
        st_q[i]  <= ST_I;
        tag_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NLINES; i++) begin
        if (p_we && p_idx == IW'(i)) begin
          st_q[i]  <= p_wst;
          tag_q[i] <= p_wtag;
        end else if (s_we && s_idx == IW'(i)) begin
          st_q[i] <= s_wst;
        end
      end
    end
  end

  assign p_st  = st_q[p_idx];
  assign p_tag = tag_q[p_idx];
  assign s_st  = st_q[s_idx];
  assign s_tag = tag_q[s_idx];

endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
  import mesi_pkg::*;
#(
  parameter int NLINES = 8,
  parameter int AW     = 16,
  localparam int IW    = $clog2(NLINES),
  localparam int TW    = AW - IW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          snp_valid,
  input  logic [1:0]    snp_cmd,
  input  logic [AW-1:0] snp_addr,
  output logic [IW-1:0] s_idx,
  input  line_st_t      s_st,
  input  logic [TW-1:0] s_tag,
  output logic          s_we,
  output line_st_t      s_wst,
  output logic          snp_shared,
  output logic          snp_flush
);

  logic      match;
  snp_resp_t resp;

  assign s_idx = snp_addr[IW-1:0];
  assign match = snp_valid && (s_st != ST_I) && (s_tag == snp_addr[AW-1:IW]);
  assign resp  = snoop_react(s_st, bus_cmd_t'(snp_cmd));
  assign s_we  = match && (resp.nxt != s_st);
  assign s_wst = resp.nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      snp_shared <= 1'b0;
      snp_flush  <= 1'b0;
    end else begin
      snp_shared <= match && resp.shared;
      snp_flush  <= match && resp.flush;
    end
  end

endmodule

// File: rtl/mesi_req_fsm.sv
module mesi_req_fsm
  import mesi_pkg::*;
#(
  parameter int NLINES = 8,
  parameter int AW     = 16,
  localparam int IW    = $clog2(NLINES),
  localparam int TW    = AW - IW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_req,
  input  logic          cpu_wr,
  input  logic [AW-1:0] cpu_addr,
  input  logic          snp_valid,
  input  logic          bus_gnt,
  input  logic          bus_shared_in,
  output logic [IW-1:0] p_idx,
  input  line_st_t      p_st,
  input  logic [TW-1:0] p_tag,
  output logic          p_we,
  output line_st_t      p_wst,
  output logic [TW-1:0] p_wtag,
  output logic          cpu_done,
  output logic          cpu_hit,
  output logic          cpu_stall,
  output logic          bus_req,
  output logic [1:0]    bus_cmd,
  output logic [AW-1:0] bus_addr,
  output logic          wb_req,
  output logic [AW-1:0] wb_addr
);

  logic          busy_q, pwr_q, done_q, hit_q, wb_q;
  logic [AW-1:0] paddr_q, wbaddr_q;
  logic [AW-1:0] lk_addr;
  logic [TW-1:0] lk_tag;
  logic          tag_match, wr_hit, is_hit, accept, grant;
  bus_cmd_t      cmd_c;

  // while a request is pending the lookup follows the held address
  assign lk_addr   = busy_q ? paddr_q : cpu_addr;
  assign p_idx     = lk_addr[IW-1:0];
  assign lk_tag    = lk_addr[AW-1:IW];
  assign tag_match = (p_st != ST_I) && (p_tag == lk_tag);
  assign wr_hit    = tag_match && (p_st == ST_E || p_st == ST_M);
  assign is_hit    = cpu_wr ? wr_hit : tag_match;
  assign accept    = !busy_q && cpu_req && !snp_valid && !done_q;
  assign grant     = busy_q && bus_gnt;

  // command follows the live line state, so a lost upgrade turns into RDX
  always_comb begin
    if (!busy_q)     cmd_c = CMD_NONE;
    else if (!pwr_q) cmd_c = CMD_RD;
    else if (tag_match && p_st == ST_S) cmd_c = CMD_UPGR;
    else             cmd_c = CMD_RDX;
  end

  always_comb begin
    p_we   = 1'b0;
    p_wst  = ST_M;
    p_wtag = lk_tag;
    if (accept && is_hit && cpu_wr) begin
      p_we  = 1'b1;
      p_wst = ST_M;
    end
    if (grant) begin
      p_we  = 1'b1;
      p_wst = pwr_q ? ST_M : (bus_shared_in ? ST_S : ST_E);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      pwr_q    <= 1'b0;
      done_q   <= 1'b0;
      hit_q    <= 1'b0;
      wb_q     <= 1'b0;
      paddr_q  <= '0;
      wbaddr_q <= '0;
    end else begin
      done_q <= 1'b0;
      hit_q  <= 1'b0;
      wb_q   <= 1'b0;
      if (accept) begin
        if (is_hit) begin
          done_q <= 1'b1;
          hit_q  <= 1'b1;
        end else begin
          busy_q  <= 1'b1;
          pwr_q   <= cpu_wr;
          paddr_q <= cpu_addr;
        end
      end
      if (grant) begin
        busy_q   <= 1'b0;
        done_q   <= 1'b1;
        wb_q     <= (p_st == ST_M) && (p_tag != lk_tag);
        wbaddr_q <= {p_tag, p_idx};
      end
    end
  end

  assign cpu_done  = done_q;
  assign cpu_hit   = hit_q;
  assign cpu_stall = busy_q;
  assign bus_req   = busy_q;
  assign bus_cmd   = cmd_c;
  assign bus_addr  = paddr_q;
  assign wb_req    = wb_q;
  assign wb_addr   = wbaddr_q;

endmodule

// File: rtl/mesi_coherence_ctrl.sv
module mesi_coherence_ctrl
  import mesi_pkg::*;
#(
  parameter int NLINES = 8,
  parameter int AW     = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_req,
  input  logic          cpu_wr,
  input  logic [AW-1:0] cpu_addr,
  output logic          cpu_done,
  output logic          cpu_hit,
  output logic          cpu_stall,
  output logic          bus_req,
  output logic [1:0]    bus_cmd,
  output logic [AW-1:0] bus_addr,
  input  logic          bus_gnt,
  input  logic          bus_shared_in,
  input  logic          snp_valid,
  input  logic [1:0]    snp_cmd,
  input  logic [AW-1:0] snp_addr,
  output logic          snp_shared,
  output logic          snp_flush,
  output logic          wb_req,
  output logic [AW-1:0] wb_addr
);

  localparam int IW = $clog2(NLINES);
  localparam int TW = AW - IW;

  logic [IW-1:0] p_idx, s_idx;
  line_st_t      p_st, s_st, p_wst, s_wst;
  logic [TW-1:0] p_tag, s_tag, p_wtag;
  logic          p_we, s_we;

  mesi_line_store #(.NLINES(NLINES), .TW(TW)) u_store (
    .clk(clk), .rst(rst),
    .p_idx(p_idx), .p_st(p_st), .p_tag(p_tag),
    .s_idx(s_idx), .s_st(s_st), .s_tag(s_tag),
    .p_we(p_we), .p_wst(p_wst), .p_wtag(p_wtag),
    .s_we(s_we), .s_wst(s_wst)
  );

  mesi_req_fsm #(.NLINES(NLINES), .AW(AW)) u_req (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .snp_valid(snp_valid), .bus_gnt(bus_gnt), .bus_shared_in(bus_shared_in),
    .p_idx(p_idx), .p_st(p_st), .p_tag(p_tag),
    .p_we(p_we), .p_wst(p_wst), .p_wtag(p_wtag),
    .cpu_done(cpu_done), .cpu_hit(cpu_hit), .cpu_stall(cpu_stall),
    .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .wb_req(wb_req), .wb_addr(wb_addr)
  );

  mesi_snoop_unit #(.NLINES(NLINES), .AW(AW)) u_snp (
    .clk(clk), .rst(rst),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .s_idx(s_idx), .s_st(s_st), .s_tag(s_tag),
    .s_we(s_we), .s_wst(s_wst),
    .snp_shared(snp_shared), .snp_flush(snp_flush)
  );

endmodule

// File: rtl/mesi_ctrl_checker.sv
module mesi_ctrl_checker #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          cpu_done,
  input logic          cpu_hit,
  input logic          cpu_stall,
  input logic          bus_req,
  input logic          bus_gnt,
  input logic [AW-1:0] bus_addr,
  input logic          snp_valid,
  input logic [1:0]    snp_cmd,
  input logic          snp_shared,
  input logic          snp_flush,
  input logic          wb_req
);

  // R11: a pending request holds until granted
  a_r11_req_held: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_gnt |=> bus_req && $stable(bus_addr));

  // R11: no completion while stalled on the bus
  a_r11_stall_no_done: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> cpu_stall && !cpu_done);

  // R11: a grant completes the request in one cycle as a miss
  a_r11_grant_completes: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_gnt |=> !bus_req && cpu_done && !cpu_hit);

  // R3: a hit never came through the bus
  a_r3_hit_without_bus: assert property (@(posedge clk) disable iff (rst)
    cpu_hit |-> cpu_done && !$past(bus_req));

  // R12: write-back only at completion of a bus transaction
  a_r12_wb_on_grant: assert property (@(posedge clk) disable iff (rst)
    wb_req |-> $past(bus_req && bus_gnt));

  // R10: snoop responses only follow a snoop
  a_r10_resp_needs_snoop: assert property (@(posedge clk) disable iff (rst)
    (snp_shared || snp_flush) |-> $past(snp_valid));

  // R7: a flush caused by a snooped read also claims sharing
  a_r7_read_flush_shared: assert property (@(posedge clk) disable iff (rst)
    (snp_flush && $past(snp_cmd) == 2'b01) |-> snp_shared);

endmodule

bind mesi_coherence_ctrl mesi_ctrl_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst),
  .cpu_done(cpu_done), .cpu_hit(cpu_hit), .cpu_stall(cpu_stall),
  .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_addr(bus_addr),
  .snp_valid(snp_valid), .snp_cmd(snp_cmd),
  .snp_shared(snp_shared), .snp_flush(snp_flush),
  .wb_req(wb_req)
);

// File: tb/sim_mesi_coherence_ctrl.sv
`timescale 1ns/1ps
module sim_mesi_coherence_ctrl;

  localparam int AW = 16;
  localparam logic [1:0] C_NONE = 2'b00, C_RD = 2'b01, C_RDX = 2'b10, C_UPG = 2'b11;

  logic          clk = 1'b0, rst = 1'b1;
  logic          cpu_req = 0, cpu_wr = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic          cpu_done, cpu_hit, cpu_stall;
  logic          bus_req;
  logic [1:0]    bus_cmd;
  logic [AW-1:0] bus_addr;
  logic          bus_gnt = 0, bus_shared_in = 0;
  logic          snp_valid = 0;
  logic [1:0]    snp_cmd = '0;
  logic [AW-1:0] snp_addr = '0;
  logic          snp_shared, snp_flush, wb_req;
  logic [AW-1:0] wb_addr;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  mesi_coherence_ctrl u0 (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_done(cpu_done), .cpu_hit(cpu_hit), .cpu_stall(cpu_stall),
    .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_gnt(bus_gnt), .bus_shared_in(bus_shared_in),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .snp_shared(snp_shared), .snp_flush(snp_flush),
    .wb_req(wb_req), .wb_addr(wb_addr)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // one processor access; dly = cycles before grant, shr = shared line on grant
  task automatic cpu_op(input bit wr, input logic [AW-1:0] a, input int dly,
                        input bit shr, input bit exp_hit, input logic [1:0] exp_cmd,
                        input bit exp_wb, input logic [AW-1:0] exp_wba, input string rq);
    @(negedge clk);
    cpu_req = 1; cpu_wr = wr; cpu_addr = a;
    @(negedge clk);
    if (exp_hit) begin
      chk(cpu_done && cpu_hit, rq, "hit done", {cpu_done, cpu_hit}, 2'b11);
      chk(!bus_req, rq, "no bus on hit", bus_req, 0);
    end else begin
      chk(bus_req && cpu_stall && !cpu_done, rq, "pending", {bus_req, cpu_stall, cpu_done}, 3'b110);
      chk(bus_cmd == exp_cmd, rq, "bus cmd", bus_cmd, exp_cmd);
      chk(bus_addr == a, rq, "bus addr", bus_addr, a);
      for (int i = 0; i < dly; i++) begin
        @(negedge clk);
        chk(bus_req && cpu_stall && !cpu_done && bus_cmd == exp_cmd, rq, "held",
            {bus_req, cpu_stall, cpu_done}, 3'b110);
      end
      bus_gnt = 1; bus_shared_in = shr;
      @(negedge clk);
      bus_gnt = 0; bus_shared_in = 0;
      chk(cpu_done && !cpu_hit && !cpu_stall && !bus_req, rq, "completion",
          {cpu_done, cpu_hit, cpu_stall, bus_req}, 4'b1000);
      chk(wb_req == exp_wb, rq, "wb_req", wb_req, exp_wb);
      if (exp_wb) chk(wb_addr == exp_wba, rq, "wb_addr", wb_addr, exp_wba);
    end
    cpu_req = 0;
    @(negedge clk);
  endtask

  task automatic snoop(input logic [1:0] cmd, input logic [AW-1:0] a,
                       input bit exp_sh, input bit exp_fl, input string rq);
    @(negedge clk);
    snp_valid = 1; snp_cmd = cmd; snp_addr = a;
    @(negedge clk);
    snp_valid = 0;
    chk(snp_shared == exp_sh, rq, "snp_shared", snp_shared, exp_sh);
    chk(snp_flush == exp_fl, rq, "snp_flush", snp_flush, exp_fl);
  endtask

  task automatic t_reset;
    chk(!cpu_done && !cpu_hit && !cpu_stall && !bus_req && !snp_shared && !snp_flush && !wb_req,
        "R1", "outputs after reset", {cpu_done, bus_req, snp_shared, wb_req}, 0);
    cpu_op(0, 16'h0000, 0, 0, 0, C_RD, 0, '0, "R1");
  endtask

  task automatic t_exclusive_path;  // line 0x0011
    cpu_op(0, 16'h0011, 2, 0, 0, C_RD, 0, '0, "R2");   // fills E
    cpu_op(1, 16'h0011, 0, 0, 1, C_NONE, 0, '0, "R6"); // silent E->M
    snoop(C_RD, 16'h0011, 1, 1, "R7");                // M supplies, -> S
    cpu_op(0, 16'h0011, 0, 0, 1, C_NONE, 0, '0, "R3");
    cpu_op(1, 16'h0011, 1, 0, 0, C_UPG, 0, '0, "R7"); // proves S after downgrade
  endtask

  task automatic t_shared_fill;  // line 0x0022
    cpu_op(0, 16'h0022, 0, 1, 0, C_RD, 0, '0, "R2");   // fills S
    cpu_op(1, 16'h0022, 0, 0, 0, C_UPG, 0, '0, "R5");  // S->M via upgrade
    snoop(C_RDX, 16'h0022, 0, 1, "R9");               // M supplies and drops
    cpu_op(0, 16'h0022, 0, 0, 0, C_RD, 0, '0, "R9");   // miss again, E
    snoop(C_UPG, 16'h0022, 0, 0, "R9");
    cpu_op(0, 16'h0022, 0, 0, 0, C_RD, 0, '0, "R9");
  endtask

  task automatic t_write_miss;  // line 0x0033
    cpu_op(1, 16'h0033, 3, 0, 0, C_RDX, 0, '0, "R4");
    cpu_op(0, 16'h0033, 0, 0, 1, C_NONE, 0, '0, "R4");
    snoop(C_RD, 16'h0033, 1, 1, "R4");                // flush proves M
  endtask

  task automatic t_snoop_miss_and_evict;  // index 4, tags of 0x0044 and 0x004C
    cpu_op(0, 16'h0044, 0, 0, 0, C_RD, 0, '0, "R2");   // E
    snoop(C_RDX, 16'h004C, 0, 0, "R10");              // same index, other tag
    snoop(C_RD, 16'h0045, 0, 0, "R10");               // invalid line
    cpu_op(1, 16'h0044, 0, 0, 1, C_NONE, 0, '0, "R10"); // still E: silent write
    cpu_op(0, 16'h004C, 0, 1, 0, C_RD, 1, 16'h0044, "R12");
    cpu_op(0, 16'h0044, 0, 0, 0, C_RD, 0, '0, "R12");  // clean S evicted: no wb
  endtask

  task automatic t_exclusive_snoop;  // line 0x0056
    cpu_op(0, 16'h0056, 0, 0, 0, C_RD, 0, '0, "R8");
    snoop(C_RD, 16'h0056, 1, 0, "R8");
    cpu_op(1, 16'h0056, 0, 0, 0, C_UPG, 0, '0, "R8");  // proves E->S
  endtask

  task automatic t_lost_upgrade;  // line 0x0067
    cpu_op(0, 16'h0067, 0, 1, 0, C_RD, 0, '0, "R11");  // S
    snoop(C_RD, 16'h0067, 1, 0, "R8");
    @(negedge clk);
    cpu_req = 1; cpu_wr = 1; cpu_addr = 16'h0067;
    @(negedge clk);
    chk(bus_req && bus_cmd == C_UPG, "R11", "upgrade pending", bus_cmd, C_UPG);
    snp_valid = 1; snp_cmd = C_RDX; snp_addr = 16'h0067;
    @(negedge clk);
    snp_valid = 0;
    chk(snp_shared == 0 && snp_flush == 0, "R11", "snoop on S", {snp_shared, snp_flush}, 0);
    chk(bus_req && bus_cmd == C_RDX, "R11", "cmd after invalidate", bus_cmd, C_RDX);
    bus_gnt = 1;
    @(negedge clk);
    bus_gnt = 0;
    chk(cpu_done && !cpu_hit, "R11", "completion", {cpu_done, cpu_hit}, 2'b10);
    cpu_req = 0;
    @(negedge clk);
    snoop(C_RD, 16'h0067, 1, 1, "R11");               // ended in M
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_exclusive_path();
    t_shared_fill();
    t_write_miss();
    t_snoop_miss_and_evict();
    t_exclusive_snoop();
    t_lost_upgrade();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule